// File: doc/BRIEF.md
# Sequential Line Prefetcher

This block sits beside a cache controller and turns each demand miss into a short burst of speculative line fills. When a miss is accepted, the block first offers the missed line itself to the memory fill port. Only after that demand fill has been handed over does it walk forward through the next consecutive lines, in ascending order. It covers a fixed window of `WINDOW_BYTES` (256 bytes, four 64-byte lines by default) that starts at the line just after the miss. Before offering each candidate line, it asks the cache's tag array whether that line is already resident. Resident lines are skipped without touching memory.

The walk never leaves the page of the line that missed (4 KB by default). A fresh miss ends whatever remains of the current window and starts a new one from the new address. A demand fill always goes ahead of any pending prefetch on the shared fill port. The block exposes `busy` and a running count of issued prefetches so the surrounding logic can observe it.

Both data interfaces use valid/ready. A miss is taken on a cycle where `miss_valid` and `miss_ready` are both high. `miss_ready` is low while a demand fill is still waiting for the fill port, so the cache controller must hold its miss. A fill request is taken on a cycle where `fill_valid` and `fill_ready` are both high. A demand request (`fill_pf` low) stays stable until it is taken. A prefetch request is speculative and can be withdrawn or replaced before it is taken: a probe hit, or a new miss, can pull it.

Top module: `seq_line_prefetch`

## Requirements
- R1: After reset, `busy`, `fill_valid` and `probe_valid` are low, `miss_ready` is high and `pf_count` is zero.
- R2: The cycle after a miss is accepted, `fill_valid` is high with `fill_pf` = 0 and `fill_addr` equal to the miss address with its low 6 bits cleared. That request holds until `fill_ready` is seen.
- R3: `miss_ready` is low on every cycle in which a demand fill is still waiting, so no second miss is taken then.
- R4: No prefetch is offered before the demand fill handshake. The first candidate, offered the cycle after that handshake, is the demand address plus 64.
- R5: Candidates ascend by 64 bytes, one step per cycle, and at most 4 candidates (256 bytes) are walked per miss.
- R6: Each candidate is presented on `probe_valid`/`probe_addr`. When `probe_hit` is high in that cycle, `fill_valid` stays low and the walk moves on to the next candidate in the following cycle, with no memory request for the skipped line.
- R7: No candidate is offered whose address lies in a different 4 KB page (bits 31:12) than the missed line. A miss in the last line of a page produces no prefetch at all.
- R8: A miss accepted while a window is in progress discards the rest of that window. The next prefetches come from the new miss address.
- R9: While a demand fill is waiting, every offered fill request is that demand (`fill_pf` = 0). A prefetch request whose demand has not yet been taken never wins.
- R10: `pf_count` rises by one for each prefetch handshake (`fill_valid`, `fill_ready` and `fill_pf` all high), and is otherwise unchanged. `busy` is high exactly while a demand fill is waiting or a window has candidates left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Demand miss offered |
| miss_ready | output | 1 | Miss can be taken this cycle |
| miss_addr | input | ADDR_W | Byte address of the missing access |
| fill_valid | output | 1 | Line-fill request offered |
| fill_ready | input | 1 | Fill port takes the request |
| fill_addr | output | ADDR_W | Line-aligned byte address to fill |
| fill_pf | output | 1 | 1 = prefetch, 0 = demand fill |
| probe_valid | output | 1 | Tag probe of a prefetch candidate |
| probe_addr | output | ADDR_W | Line-aligned candidate address |
| probe_hit | input | 1 | Same-cycle answer: candidate already cached |
| busy | output | 1 | Demand waiting or window in progress |
| pf_count | output | CNT_W | Number of prefetch handshakes, wrapping |

## Verification
The collision of interest comes when a prefetch handshake and the acceptance of a new miss land in the same cycle. In that case the prefetch must be counted and the old window must still be dropped. The bench provokes this by raising `miss_valid` in exactly the cycle where a candidate is offered with `fill_ready` high. It then runs a long random mix of misses, back-pressure and resident lines. A behavioural model, built on a queue of outstanding candidate addresses, predicts every output in every cycle and judges which request wins and what `pf_count` becomes.

// File: rtl/pf_pkg.sv
package pf_pkg;

  // Source of the request currently shown on the fill port.
  typedef enum logic [1:0] {
    SRC_NONE     = 2'd0,
    SRC_DEMAND   = 2'd1,
    SRC_PREFETCH = 2'd2
  } fill_src_e;

  // Number of lines covered by a window of a given byte size.
  function automatic int unsigned lines_in(input int unsigned bytes_n,
                                           input int unsigned line_bytes);
    return bytes_n / line_bytes;
  endfunction

endpackage

// File: rtl/pf_demand_slot.sv
module pf_demand_slot #(
  parameter int LA_W = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LA_W-1:0] load_line,
  input  logic            taken,
  output logic            pend,
  output logic [LA_W-1:0] line
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      line <= '0;
    end else if (load) begin
      pend <= 1'b1;
      line <= load_line;
    end else if (taken) begin
      pend <= 1'b0;
    end
  end

  // A waiting demand keeps its line until the fill port takes it.
  p_hold_demand_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !taken) |=> (pend && $stable(line)));

  // No new miss may be loaded over a waiting demand.
  p_no_overwrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !load);

endmodule

// File: rtl/pf_stream_walker.sv
module pf_stream_walker #(
  parameter int LA_W           = 26,
  parameter int WIN_LINES      = 4,
  parameter int PAGE_LINE_BITS = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LA_W-1:0] base_line,
  input  logic            cancel,
  input  logic            step,
  output logic            act,
  output logic [LA_W-1:0] cand
);

  localparam int LEFT_W = $clog2(WIN_LINES + 1);

  logic [LEFT_W-1:0] left;
  logic              base_last;
  logic              cand_last;

  assign base_last = &base_line[PAGE_LINE_BITS-1:0];
  assign cand_last = &cand[PAGE_LINE_BITS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      cand <= '0;
      left <= '0;
    end else if (cancel) begin
      act  <= 1'b0;
    end else if (start) begin
      act  <= (WIN_LINES > 0) && !base_last;
      cand <= base_line + 1'b1;
      left <= LEFT_W'(WIN_LINES);
    end else if (step && act) begin
      cand <= cand + 1'b1;
      left <= left - 1'b1;
      if (left == LEFT_W'(1) || cand_last) act <= 1'b0;
    end
  end

  // Checker state: page of the window and steps taken in it.
  logic [LA_W-PAGE_LINE_BITS-1:0] chk_page;
  logic [LEFT_W:0]                chk_steps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_page  <= '0;
      chk_steps <= '0;
    end else if (start) begin
      chk_page  <= base_line[LA_W-1:PAGE_LINE_BITS];
      chk_steps <= '0;
    end else if (step && act) begin
      chk_steps <= chk_steps + 1'b1;
    end
  end

  p_window_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !start) |-> (chk_steps < (LEFT_W+1)'(WIN_LINES)));

  p_same_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !start) |-> (cand[LA_W-1:PAGE_LINE_BITS] == chk_page));

  p_ascend_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && step && !cancel && !start) |=> (!act || cand == $past(cand) + 1'b1));

endmodule

// File: rtl/pf_issue_arb.sv
module pf_issue_arb
  import pf_pkg::*;
#(
  parameter int LA_W = 26
) (
  input  logic            dem_pend,
  input  logic [LA_W-1:0] dem_line,
  input  logic            pf_act,
  input  logic [LA_W-1:0] pf_line,
  input  logic            probe_hit,
  input  logic            fill_ready,
  output logic            probe_valid,
  output logic            fill_valid,
  output logic [LA_W-1:0] fill_line,
  output fill_src_e       src,
  output logic            dem_taken,
  output logic            pf_issue,
  output logic            pf_step
);

  logic pf_offer;

  always_comb begin
    pf_offer    = pf_act && !dem_pend;
    probe_valid = pf_offer;
    if (dem_pend)                   src = SRC_DEMAND;
    else if (pf_offer && !probe_hit) src = SRC_PREFETCH;
    else                            src = SRC_NONE;
    fill_valid = (src != SRC_NONE);
    fill_line  = dem_pend ? dem_line : pf_line;
    dem_taken  = (src == SRC_DEMAND) && fill_ready;
    pf_issue   = (src == SRC_PREFETCH) && fill_ready;
    pf_step    = pf_offer && (probe_hit || fill_ready);
  end

  // Demand priority: a waiting demand never lets a prefetch through.
  always_comb begin
    if (dem_pend) a_demand_first_r9: assert (!pf_issue);
  end

endmodule

// File: rtl/pf_counter.sv
module pf_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (inc) count <= count + 1'b1;
  end

endmodule

// File: rtl/seq_line_prefetch.sv
module seq_line_prefetch
  import pf_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter int WINDOW_BYTES = 256,
  parameter int PAGE_BYTES   = 4096,
  parameter int CNT_W        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              fill_valid,
  input  logic              fill_ready,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_pf,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  input  logic              probe_hit,
  output logic              busy,
  output logic [CNT_W-1:0]  pf_count
);

  localparam int LINE_BITS      = $clog2(LINE_BYTES);
  localparam int LA_W           = ADDR_W - LINE_BITS;
  localparam int WIN_LINES      = int'(lines_in(WINDOW_BYTES, LINE_BYTES));
  localparam int PAGE_LINE_BITS = $clog2(PAGE_BYTES) - LINE_BITS;

  logic            miss_fire;
  logic            dem_pend;
  logic [LA_W-1:0] dem_line;
  logic            dem_taken;
  logic            pf_act;
  logic [LA_W-1:0] pf_line;
  logic            pf_issue;
  logic            pf_step;
  logic [LA_W-1:0] fill_line;
  fill_src_e       src;

  assign miss_ready = !dem_pend;
  assign miss_fire  = miss_valid && miss_ready;

  pf_demand_slot #(.LA_W(LA_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (miss_fire),
    .load_line (miss_addr[ADDR_W-1:LINE_BITS]),
    .taken     (dem_taken),
    .pend      (dem_pend),
    .line      (dem_line)
  );

  pf_stream_walker #(
    .LA_W           (LA_W),
    .WIN_LINES      (WIN_LINES),
    .PAGE_LINE_BITS (PAGE_LINE_BITS)
  ) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (dem_taken),
    .base_line (dem_line),
    .cancel    (miss_fire),
    .step      (pf_step),
    .act       (pf_act),
    .cand      (pf_line)
  );

  pf_issue_arb #(.LA_W(LA_W)) u_arb (
    .dem_pend    (dem_pend),
    .dem_line    (dem_line),
    .pf_act      (pf_act),
    .pf_line     (pf_line),
    .probe_hit   (probe_hit),
    .fill_ready  (fill_ready),
    .probe_valid (probe_valid),
    .fill_valid  (fill_valid),
    .fill_line   (fill_line),
    .src         (src),
    .dem_taken   (dem_taken),
    .pf_issue    (pf_issue),
    .pf_step     (pf_step)
  );

  pf_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (pf_issue),
    .count (pf_count)
  );

  assign fill_addr  = {fill_line, {LINE_BITS{1'b0}}};
  assign fill_pf    = (src == SRC_PREFETCH);
  assign probe_addr = {pf_line, {LINE_BITS{1'b0}}};
  assign busy       = dem_pend || pf_act;

  // An accepted miss shows up as a demand fill on the next cycle.
  p_demand_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> (fill_valid && !fill_pf));

  // First candidate after a demand handshake is the next line.
  p_first_pf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && !fill_pf)
      |=> (!probe_valid || probe_addr == $past(fill_addr) + ADDR_W'(LINE_BYTES)));

  // A resident candidate is passed over: the probe moves on or stops.
  p_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && probe_hit) |=> (!probe_valid || probe_addr != $past(probe_addr)));

  // Count follows prefetch handshakes.
  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_ready && fill_pf) |=> (pf_count == $past(pf_count) + 1'b1));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && fill_ready && fill_pf) |=> $stable(pf_count));

endmodule

// File: tb/tb_seq_line_prefetch.sv
`timescale 1ns/100ps
module tb_seq_line_prefetch;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_addr = '0;
  logic        fill_valid;
  logic        fill_ready = 1'b0;
  logic [31:0] fill_addr;
  logic        fill_pf;
  logic        probe_valid;
  logic [31:0] probe_addr;
  logic        probe_hit;
  logic        busy;
  logic [15:0] pf_count;
  logic [63:0] cmap = '0;  // resident lines, indexed by address bits 11:6

  always #2.5 clk = ~clk;  // 200 MHz

  assign probe_hit = probe_valid && cmap[probe_addr[11:6]];

  seq_line_prefetch dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_addr(miss_addr),
    .fill_valid(fill_valid), .fill_ready(fill_ready), .fill_addr(fill_addr),
    .fill_pf(fill_pf), .probe_valid(probe_valid), .probe_addr(probe_addr),
    .probe_hit(probe_hit), .busy(busy), .pf_count(pf_count)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string scen  = "R1";

  // Behavioural reference: a waiting demand plus a queue of candidates.
  bit          m_dem = 0;
  logic [31:0] m_daddr = '0;
  logic [31:0] m_q[$];
  int          m_cnt = 0;

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, scen, $time, act, exp);
    end
  endtask

  function automatic bit resident(input logic [31:0] a);
    return cmap[a[11:6]];
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      bit          e_pv, e_fv, e_fpf, e_busy, hit0, dfire;
      logic [31:0] e_pa, e_fa;
      e_pv   = !m_dem && (m_q.size() > 0);
      e_pa   = e_pv ? m_q[0] : '0;
      hit0   = e_pv && resident(e_pa);
      e_fv   = m_dem || (e_pv && !hit0);
      e_fa   = m_dem ? m_daddr : e_pa;
      e_fpf  = !m_dem;
      e_busy = m_dem || (m_q.size() > 0);
      chk("R3", miss_ready == !m_dem, miss_ready, !m_dem);
      chk(m_dem ? "R9" : "R5", fill_valid == e_fv, fill_valid, e_fv);
      if (e_fv && fill_valid) begin
        chk(m_dem ? "R2" : "R4", fill_addr == e_fa, fill_addr, e_fa);
        chk("R9", fill_pf == e_fpf, fill_pf, e_fpf);
      end
      chk("R6", probe_valid == e_pv, probe_valid, e_pv);
      if (e_pv && probe_valid) chk("R7", probe_addr == e_pa, probe_addr, e_pa);
      chk("R10", busy == e_busy, busy, e_busy);
      chk("R10", pf_count == 16'(m_cnt), pf_count, m_cnt);
      // advance the model across the coming edge
      dfire = miss_valid && !m_dem;
      if (m_dem) begin
        if (fill_ready) begin
          m_dem = 0;
          for (int k = 1; k <= 4; k++) begin
            logic [31:0] a;
            a = m_daddr + 32'(64 * k);
            if (a[31:12] != m_daddr[31:12]) break;
            m_q.push_back(a);
          end
        end
      end else if (m_q.size() > 0) begin
        if (hit0) void'(m_q.pop_front());
        else if (fill_ready) begin
          void'(m_q.pop_front());
          m_cnt++;
        end
      end
      if (dfire) begin
        m_q.delete();
        m_dem   = 1;
        m_daddr = {miss_addr[31:6], 6'b0};
      end
    end
  end

  task automatic drive(input bit mv, input logic [31:0] ma, input bit fr);
    @(posedge clk);
    #1;
    miss_valid = mv;
    miss_addr  = ma;
    fill_ready = fr;
  endtask

  task automatic idle(input int n, input bit fr);
    for (int i = 0; i < n; i++) drive(0, '0, fr);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 20000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset values
    chk("R1", busy == 0, busy, 0);
    chk("R1", fill_valid == 0, fill_valid, 0);
    chk("R1", probe_valid == 0, probe_valid, 0);
    chk("R1", miss_ready == 1, miss_ready, 1);
    chk("R1", pf_count == 0, pf_count, 0);
    rst_n = 1'b1;
    idle(2, 1);

    // R2/R4/R5: plain miss, fill port always ready, nothing resident
    scen = "R5";
    drive(1, 32'h1000_0047, 1);
    idle(8, 1);

    // R2/R3: demand held under back-pressure, second miss waits
    scen = "R3";
    drive(1, 32'h1000_0400, 0);
    drive(1, 32'h1000_0800, 0);
    drive(1, 32'h1000_0800, 0);
    drive(1, 32'h1000_0800, 0);
    drive(0, '0, 1);
    idle(10, 1);

    // R6: resident candidates are skipped
    scen = "R6";
    cmap = '0;
    cmap[5] = 1'b1;
    cmap[7] = 1'b1;
    drive(1, 32'h2000_0100, 1);
    idle(8, 1);
    cmap = '0;

    // R7: page end trims the window; last line of page gives nothing
    scen = "R7";
    drive(1, 32'h3000_0F40, 1);
    idle(6, 1);
    drive(1, 32'h3000_0FC0, 1);
    idle(4, 1);

    // R8: new miss in the cycle a prefetch is taken
    scen = "R8";
    drive(1, 32'h4000_0000, 1);
    drive(0, '0, 1);  // demand handshake
    drive(0, '0, 1);  // first prefetch taken
    drive(1, 32'h4000_0A00, 1);  // second prefetch taken, new miss same cycle
    idle(8, 1);

    // R9: prefetch offered, then withdrawn for a new demand
    scen = "R9";
    drive(1, 32'h5000_0200, 1);
    drive(0, '0, 1);
    drive(1, 32'h5000_0600, 0);  // prefetch offered, not taken, miss arrives
    drive(0, '0, 0);             // demand must be shown
    drive(0, '0, 0);
    idle(8, 1);

    // mixed random traffic
    scen = "R10";
    for (int i = 0; i < 3000; i++) begin
      bit          mv, fr;
      logic [31:0] ma;
      mv = ($urandom % 8) == 0;
      fr = ($urandom % 10) < 7;
      ma = {16'h6000, 4'($urandom % 3), 12'($urandom)};
      if ((i % 97) == 0) cmap = {$urandom, $urandom};
      drive(mv, ma, fr);
    end
    idle(10, 1);
    finish_run();
  end

endmodule